// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block connects a clocked system to an external asynchronous static RAM of 256K words by 16 bits. The host gives one request at a time: an address, a read/write flag, write data and a two-bit lane mask. When the operation is complete the block returns a one-cycle `done` pulse, together with the read data for a read. On the memory side it drives active-low chip select, write strobe, output enable and two byte-lane selects, an 18-bit address and a shared 16-bit data bus. Every memory timing minimum is given in nanoseconds. It becomes a whole number of clock cycles by rounding up against the `CLK_NS` parameter.

A state machine sequences each operation. The state names are IDLE, WR_SETUP, WR_PULSE, WR_HOLD, RD_ACCESS and RD_TURN. The transitions are as follows:
- IDLE goes to WR_SETUP on an accepted write, or to RD_ACCESS on an accepted read.
- WR_SETUP goes to WR_PULSE, then to WR_HOLD, then back to IDLE.
- RD_ACCESS goes to RD_TURN, then back to IDLE.

Each timed state leaves when its window counter reaches zero. Every pin is registered from the next state, so glitches from the decode logic never reach the memory.

With the default 20 ns clock the windows are:

| Window | Cycles |
|---|---|
| Write setup | 1 |
| Write strobe | 3 |
| Write hold | 1 |
| Read access | 4 |
| Read turnaround | 2 |

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is high, and afterwards in IDLE, the memory pins are inactive: chip select, write strobe, output enable and both lane selects are high (1). `done` is 0 and `ready` is 1.
- R2: In a write, chip select falls one cycle before the write strobe falls. The strobe then stays low for exactly max(ceil(50/T), ceil(30/T), ceil(60/T)-1) cycles, where T is the clock period; this is 3 cycles at 20 ns. The address stays stable for as long as chip select is low.
- R3: Bit 0 of `req_be` enables the low lane (data bits 7:0), and its select `sram_lb_n` goes low. Bit 1 enables the high lane (bits 15:8) through `sram_ub_n`. A lane whose mask bit is 0 keeps its select high, so the memory keeps the old contents of that byte. A mask of 00 stores nothing.
- R4: Output enable stays high whenever the write strobe is low. The controller drives the data bus from the cycle in which the strobe falls until one cycle after it rises, and during that extra cycle the bus still carries the write data.
- R5: In a read, chip select and output enable stay low, with the write strobe high, for max(ceil(70/T), ceil(35/T)) cycles (4 at 20 ns). The bus is sampled on the clock edge that ends this window.
- R6: `rd_data` returns the memory word. Any lane whose mask bit is 0 reads as zero.
- R7: Each accepted request produces exactly one `done` pulse, and the pulse lasts a single cycle. No `done` appears without a request.
- R8: A request is taken only while `ready` is high, which is only in IDLE. A request presented while the controller is busy has no effect on memory and produces no `done`.
- R9: After a read, `ready` stays low for max(1, ceil(25/T)) cycles, counted from the cycle of the read's `done` (2 at 20 ns). This turnaround lets the memory release the bus before the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; taken when `ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, disabled lanes zeroed |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | High-lane select, active low |
| sram_lb_n | output | 1 | Low-lane select, active low |
| sram_a | output | 18 | Memory address |
| sram_dq | inout | 16 | Shared data bus |

## Verification
The bench models the memory. The model stores each enabled lane on the edge that ends the overlap of chip select and write strobe, and drives only the lanes selected for a read.

The bench targets the following corner cases:
- **Partial-lane writes followed by reads with other masks.** A controller that ignored the mask would overwrite the neighbouring byte. One that failed to zero the disabled lanes would return stale bits.
- **A read followed at once by a write.** A missing turnaround would show up as `ready` returning too early.
- **A write strobe that is too short, or data released before the strobe rises.** The model would then store the wrong value, which the next read exposes.
- **Requests presented while busy.** A controller that took them would write memory or pulse `done` an extra time.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_PULSE  = 3'd2,
        ST_WR_HOLD   = 3'd3,
        ST_RD_ACCESS = 3'd4,
        ST_RD_TURN   = 3'd5
    } ctrl_state_e;

    // Smallest whole number of clock cycles covering a nanosecond minimum.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_win_timer.sv
module sram_win_timer #(
    parameter int unsigned TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
    parameter int unsigned DW    = 16,
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_wdata,
    input  logic [DW-1:0]    wdata_in,
    input  logic             drive_en,
    input  logic             capture,
    input  logic [LANES-1:0] lane_en,
    inout  wire  [DW-1:0]    dq,
    output logic [DW-1:0]    rd_data
);

    localparam int unsigned LW = DW / LANES;

    logic [DW-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (load_wdata) begin
            wdata_q <= wdata_in;
        end
    end

    assign dq = drive_en ? wdata_q : {DW{1'bz}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[g*LW +: LW] <= '0;
            end else if (capture) begin
                rd_data[g*LW +: LW] <= lane_en[g] ? dq[g*LW +: LW] : '0;
            end
        end
    end

    // R4
    bus_dir_chk: assert property (@(posedge clk) disable iff (rst)
        capture |-> !drive_en);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW           = 18,
    parameter int unsigned LANES        = 2,
    parameter int unsigned TW           = 3,
    parameter int unsigned WR_SETUP_CYC = 1,
    parameter int unsigned WR_PULSE_CYC = 3,
    parameter int unsigned WR_HOLD_CYC  = 1,
    parameter int unsigned RD_ACC_CYC   = 4,
    parameter int unsigned RD_TURN_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [LANES-1:0] req_be,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             done,
    output logic             drive_en,
    output logic [LANES-1:0] lane_en,
    output logic             pin_ce_n,
    output logic             pin_we_n,
    output logic             pin_oe_n,
    output logic [LANES-1:0] pin_byte_n,
    output logic [AW-1:0]    pin_a
);

    ctrl_state_e      state_q, state_d;
    logic [LANES-1:0] be_sel;
    logic             busy_d;

    assign ready   = (state_q == ST_IDLE);
    assign accept  = ready && req_valid;
    assign capture = (state_q == ST_RD_ACCESS) && tmr_expired;
    assign be_sel  = accept ? req_be : lane_en;
    assign busy_d  = (state_d != ST_IDLE) && (state_d != ST_RD_TURN);

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid)   state_d = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_WR_SETUP:  if (tmr_expired) state_d = ST_WR_PULSE;
            ST_WR_PULSE:  if (tmr_expired) state_d = ST_WR_HOLD;
            ST_WR_HOLD:   if (tmr_expired) state_d = ST_IDLE;
            ST_RD_ACCESS: if (tmr_expired) state_d = ST_RD_TURN;
            ST_RD_TURN:   if (tmr_expired) state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // Window length for the state being entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_WR_SETUP:  tmr_val = TW'(WR_SETUP_CYC - 1);
            ST_WR_PULSE:  tmr_val = TW'(WR_PULSE_CYC - 1);
            ST_WR_HOLD:   tmr_val = TW'(WR_HOLD_CYC - 1);
            ST_RD_ACCESS: tmr_val = TW'(RD_ACC_CYC - 1);
            ST_RD_TURN:   tmr_val = TW'(RD_TURN_CYC - 1);
            default:      tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered pins and request fields, driven from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_ce_n   <= 1'b1;
            pin_we_n   <= 1'b1;
            pin_oe_n   <= 1'b1;
            pin_byte_n <= '1;
            pin_a      <= '0;
            lane_en    <= '0;
            drive_en   <= 1'b0;
            done       <= 1'b0;
        end else begin
            pin_ce_n   <= !busy_d;
            pin_we_n   <= (state_d != ST_WR_PULSE);
            pin_oe_n   <= (state_d != ST_RD_ACCESS);
            pin_byte_n <= busy_d ? ~be_sel : '1;
            pin_a      <= accept ? req_addr : pin_a;
            lane_en    <= be_sel;
            drive_en   <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
            done       <= tmr_expired && ((state_q == ST_WR_HOLD) || (state_q == ST_RD_ACCESS));
        end
    end

    // Length of the current write-strobe low run, for the width check
    logic [7:0] we_low_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt <= '0;
        end else if (!pin_we_n) begin
            we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 8'd1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    // R2
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_we_n && we_low_cnt != 8'd0) |-> (we_low_cnt >= 8'(WR_PULSE_CYC)));

    // R2
    we_in_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_we_n |-> !pin_ce_n);

    // R4
    oe_hi_in_wr_chk: assert property (@(posedge clk) disable iff (rst)
        !pin_we_n |-> pin_oe_n);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pin_ce_n && pin_we_n && pin_oe_n && (pin_byte_n == '1)));

    // R8
    busy_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!ready && req_valid) |=> $stable(pin_a));

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW        = 18,
    parameter int unsigned DW        = 16,
    parameter int unsigned CLK_NS    = 20,
    parameter int unsigned T_WC_NS   = 70,
    parameter int unsigned T_PWE_NS  = 50,
    parameter int unsigned T_SCE_NS  = 60,
    parameter int unsigned T_SD_NS   = 30,
    parameter int unsigned T_RC_NS   = 70,
    parameter int unsigned T_DOE_NS  = 35,
    parameter int unsigned T_HZ_NS   = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic          sram_ub_n,
    output logic          sram_lb_n,
    output logic [AW-1:0] sram_a,
    inout  wire  [DW-1:0] sram_dq
);

    localparam int unsigned LANES        = 2;
    localparam int unsigned WR_SETUP_CYC = 1;
    localparam int unsigned WR_PULSE_CYC =
        max_u(max_u(ns_to_cycles(T_PWE_NS, CLK_NS), ns_to_cycles(T_SD_NS, CLK_NS)),
              ns_to_cycles(T_SCE_NS, CLK_NS) - WR_SETUP_CYC);
    localparam int unsigned WC_CYC       = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int unsigned WR_HOLD_CYC  =
        (WC_CYC > WR_SETUP_CYC + WR_PULSE_CYC + 1) ? WC_CYC - WR_SETUP_CYC - WR_PULSE_CYC : 1;
    localparam int unsigned RD_ACC_CYC   =
        max_u(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_DOE_NS, CLK_NS));
    localparam int unsigned RD_TURN_CYC  = max_u(1, ns_to_cycles(T_HZ_NS, CLK_NS));
    localparam int unsigned MAX_CYC      =
        max_u(max_u(WR_PULSE_CYC, WR_HOLD_CYC), max_u(RD_ACC_CYC, RD_TURN_CYC));
    localparam int unsigned TW           = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_expired, accept, capture, drive_en;
    logic [TW-1:0]    tmr_val;
    logic [LANES-1:0] lane_en, byte_n;

    sram_ctrl_fsm #(
        .AW(AW), .LANES(LANES), .TW(TW),
        .WR_SETUP_CYC(WR_SETUP_CYC), .WR_PULSE_CYC(WR_PULSE_CYC), .WR_HOLD_CYC(WR_HOLD_CYC),
        .RD_ACC_CYC(RD_ACC_CYC), .RD_TURN_CYC(RD_TURN_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .ready(ready), .accept(accept), .capture(capture), .done(done),
        .drive_en(drive_en), .lane_en(lane_en),
        .pin_ce_n(sram_ce_n), .pin_we_n(sram_we_n), .pin_oe_n(sram_oe_n),
        .pin_byte_n(byte_n), .pin_a(sram_a)
    );

    sram_win_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    sram_lane_io #(.DW(DW), .LANES(LANES)) u_lanes (
        .clk(clk), .rst(rst), .load_wdata(accept), .wdata_in(req_wdata),
        .drive_en(drive_en), .capture(capture), .lane_en(lane_en),
        .dq(sram_dq), .rd_data(rd_data)
    );

    assign sram_lb_n = byte_n[0];
    assign sram_ub_n = byte_n[1];

    // R4
    drive_oe_chk: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> sram_oe_n);

    // R9
    turn_ce_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> sram_ce_n);

endmodule

// File: tb/sram_byte_ctrl_bench.sv
module sram_byte_ctrl_bench;

    localparam int unsigned CLK_NS = 20;

    function automatic int unsigned cdiv(input int unsigned ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int unsigned mx(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam int unsigned EXP_PULSE = mx(mx(cdiv(50), cdiv(30)), cdiv(60) - 1);
    localparam int unsigned EXP_ACC   = mx(cdiv(70), cdiv(35));
    localparam int unsigned EXP_TURN  = mx(1, cdiv(25));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be    = '0;
    logic        ready, done;
    logic [15:0] rd_data;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
    logic [17:0] sram_a;
    wire  [15:0] sram_dq;

    always #(CLK_NS/2) clk = ~clk;

    sram_byte_ctrl u_sram_byte_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ready(ready), .done(done), .rd_data(rd_data),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_a(sram_a), .sram_dq(sram_dq)
    );

    // ---------------- memory model (folded to 64 words) ----------------
    logic [15:0] mem [64];
    logic [15:0] mem_q;
    wire rd_on = !sram_ce_n && !sram_oe_n && sram_we_n;
    wire wr_on = !sram_ce_n && !sram_we_n;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    always @* mem_q = mem[sram_a[5:0]];
    assign sram_dq[7:0]  = (rd_on && !sram_lb_n) ? mem_q[7:0]  : 8'hzz;
    assign sram_dq[15:8] = (rd_on && !sram_ub_n) ? mem_q[15:8] : 8'hzz;

    always @(negedge wr_on) begin
        if (!sram_lb_n) mem[sram_a[5:0]][7:0]  = sram_dq[7:0];
        if (!sram_ub_n) mem[sram_a[5:0]][15:8] = sram_dq[15:8];
    end

    // ---------------- bookkeeping ----------------
    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic [15:0] exp;
    } sb_item_t;

    sb_item_t    sb[$];
    logic [15:0] shadow [64];
    initial for (int i = 0; i < 64; i++) shadow[i] = 16'h0000;

    bit          last_rd = 1'b0;
    logic [15:0] cur_wdata = '0;

    // ---------------- driver ----------------
    task automatic do_op(input bit wr, input logic [17:0] addr, input logic [15:0] data,
                         input logic [1:0] be);
        sb_item_t it;
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = data;
        req_be    = be;
        if (wr) begin
            if (be[0]) shadow[addr[5:0]][7:0]  = data[7:0];
            if (be[1]) shadow[addr[5:0]][15:8] = data[15:8];
            it.rd  = 1'b0;
            it.exp = 16'h0000;
        end else begin
            it.rd  = 1'b1;
            it.exp = {be[1] ? shadow[addr[5:0]][15:8] : 8'h00,
                      be[0] ? shadow[addr[5:0]][7:0]  : 8'h00};
        end
        sb.push_back(it);
        @(posedge clk);
        last_rd   = !wr;
        cur_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // ---------------- monitor: scoreboard ----------------
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                // R7: single-cycle pulse
                check_eq("R7 done lasts one cycle", {31'd0, prev_done}, 32'd0);
                if (sb.size() == 0) begin
                    check_eq("R7 done without request (R8)", 32'd1, 32'd0);
                end else begin
                    sb_item_t it;
                    it = sb.pop_front();
                    if (it.rd) check_eq("R6 read data masked", {16'd0, rd_data}, {16'd0, it.exp});
                    else       check_eq("R7 write completion", 32'd1, 32'd1);
                end
            end
            prev_done = done;
        end
    end

    // ---------------- monitor: pin timing ----------------
    bit          prev_we_n = 1'b1, prev_ce_n = 1'b1;
    logic [17:0] prev_a = '0;
    int          we_lo = 0, oe_lo = 0, turn_cnt = 0;
    bit          turn_arm = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_we_n) begin
                check_eq("R4 oe_n high while we_n low", {31'd0, sram_oe_n}, 32'd1);
                we_lo++;
            end else if (we_lo != 0) begin
                check_eq("R2 we_n low width", we_lo, EXP_PULSE);
                check_eq("R4 data held after we_n rises", {16'd0, sram_dq}, {16'd0, cur_wdata});
                we_lo = 0;
            end
            if (!sram_we_n && prev_we_n)
                check_eq("R2 ce_n low before we_n falls", {31'd0, prev_ce_n}, 32'd0);
            if (!sram_ce_n && !prev_ce_n)
                check_eq("R2 address stable while selected", {14'd0, sram_a}, {14'd0, prev_a});
            if (!sram_oe_n) begin
                check_eq("R5 we_n high during read", {31'd0, sram_we_n}, 32'd1);
                oe_lo++;
            end else if (oe_lo != 0) begin
                check_eq("R5 read access width", oe_lo, EXP_ACC);
                oe_lo = 0;
            end
            // R9 turnaround
            if (done && last_rd) begin
                turn_arm = 1'b1;
                turn_cnt = ready ? 0 : 1;
            end else if (turn_arm && !ready) begin
                turn_cnt++;
            end
            if (turn_arm && ready) begin
                check_eq("R9 read turnaround cycles", turn_cnt, EXP_TURN);
                turn_arm = 1'b0;
            end
            prev_we_n = sram_we_n;
            prev_ce_n = sram_ce_n;
            prev_a    = sram_a;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1 reset pins", {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n},
                 32'h1F);
        check_eq("R1 reset done/ready", {30'd0, done, ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 idle pins after reset", {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n,
                 sram_lb_n}, 32'h1F);

        // Full-word write and read
        do_op(1'b1, 18'h00005, 16'h1234, 2'b11);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11);
        // R3: low-lane-only write keeps high byte
        do_op(1'b1, 18'h00005, 16'hABCD, 2'b01);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11);
        // R3: high-lane-only write keeps low byte
        do_op(1'b1, 18'h00005, 16'h56EE, 2'b10);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11);
        // R6: masked reads
        do_op(1'b0, 18'h00005, 16'h0000, 2'b01);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b10);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b00);
        // R3: empty mask stores nothing
        do_op(1'b1, 18'h00005, 16'hFFFF, 2'b00);
        do_op(1'b0, 18'h00005, 16'h0000, 2'b11);

        // Boundary addresses, read-then-write and write-then-read
        do_op(1'b1, 18'h3FFFF, 16'hA5A5, 2'b11);
        do_op(1'b1, 18'h00000, 16'h5A5A, 2'b11);
        do_op(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
        do_op(1'b1, 18'h00011, 16'hC3C3, 2'b11);
        do_op(1'b0, 18'h00000, 16'h0000, 2'b11);
        do_op(1'b0, 18'h00011, 16'h0000, 2'b11);

        // R8: request while busy is ignored
        do_op(1'b1, 18'h00020, 16'h7777, 2'b11);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 18'h00021;
        req_wdata = 16'hDEAD;
        req_be    = 2'b11;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        do_op(1'b0, 18'h00021, 16'h0000, 2'b11);
        do_op(1'b0, 18'h00020, 16'h0000, 2'b11);

        // Pattern sweep
        for (int i = 0; i < 6; i++)
            do_op(1'b1, 18'(i * 7 + 40) & 18'h0003F, 16'(16'h1111 * (i + 1)), 2'(i % 3 + 1));
        for (int i = 0; i < 6; i++)
            do_op(1'b0, 18'(i * 7 + 40) & 18'h0003F, 16'h0000, 2'b11);

        repeat (10) @(negedge clk);
        check_eq("R7 every request completed", sb.size(), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule